// File: doc/BRIEF.md
# Hardware-Monitor Register Bank with Write-Once Limits

This block is the byte-wide register file of a hardware-monitor device. A host reaches it through one synchronous port made of an address, a write strobe, write data and a read-data return. Writes land on the rising clock edge. Reads are combinational from the address that is presented.

The block holds:
- a general configuration register that can also trigger a soft re-initialise;
- a channel-mode register whose top bit is the global external-interrupt enable;
- two temperature high limits;
- a voltage-ID / fan-divisor register;
- a second voltage-ID register with spare storage;
- a second configuration register for interrupt masking, lock bits and thermal-output mode.

The live voltage-ID pins show up as read-only fields. The two fan divisor selects are exported as decoded divide ratios.

Each temperature limit can be frozen by a lock bit. Once a lock bit is set, only reset or the soft re-initialise command can clear it. The block also drives an active-low interrupt. That interrupt combines a thermal event with two of the voltage-ID pins, which can serve as synchronised, individually enabled interrupt inputs.

Top module: `hwmon_regbank`

## Requirements
- R1: After reset the registers read as follows:
  - 40h reads 00h, 16h reads 00h and 4Ah reads 00h.
  - 13h reads 50h and 14h reads 55h.
  - 47h reads {0101, vid[3:0]}.
  - 49h reads {1000000, vid[4]}.
- R2: Register 47h has a live low nibble and a stored high nibble.
  - Bits 3:0 always return vid[3:0], and writes to them have no effect.
  - Bits 7:4 are stored read/write.
- R3: Register 49h has a live bit 0 and stored upper bits.
  - Bit 0 always returns vid[4] and is not writable.
  - Bits 7:1 are stored read/write.
- R4: The fan divisor outputs are decoded from register 47h.
  - fan_div_o[3:0] equals 1 shifted left by 47h[5:4].
  - fan_div_o[7:4] equals 1 shifted left by 47h[7:6].
  - Code 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R5: The temperature limits can be write-locked.
  - While 4Ah bit 1 is 1, writes to 13h are ignored.
  - While 4Ah bit 2 is 1, writes to 14h are ignored.
  - Writing 0 to a set lock bit does not clear it.
- R6: Writing 40h with bit 7 = 1 returns every register to its reset value on the next clock, including both lock bits. Bit 7 of 40h always reads 0. Bits 6:0 of 40h are stored read/write.
- R7: Thermal events and the mask behave as follows:
  - With 4Ah bit 0 = 0, a high therm_evt_i drives irq_n_o low one clock later.
  - With 4Ah bit 0 = 1, therm_evt_i does not affect irq_n_o.
- R8: acpi_mode_o equals 4Ah bit 3 (0 selects default mode, 1 selects ACPI mode).
- R9: vid[3] and vid[4] can act as interrupt inputs.
  - When 4Ah bit 6 and 16h bit 7 are both 1, vid[3] high drives irq_n_o low exactly three clocks after the pin rises: two synchroniser stages plus the output flop. 4Ah bit 7 does the same for vid[4].
  - Without the global enable, the pins have no effect on irq_n_o.
- R10: Addresses outside the implemented set read 00h, and writes to them change no register. Bits 5:4 of 4Ah always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data for addr_i |
| vid_i | input | 5 | Voltage-ID pins; bits 3 and 4 can be interrupt sources |
| therm_evt_i | input | 1 | Thermal error event, active high |
| irq_n_o | output | 1 | Interrupt output, active low |
| acpi_mode_o | output | 1 | Thermal output mode select |
| fan_div_o | output | 8 | Decoded fan divide ratios, 4 bits per fan |

## Verification
A lock bit that fails to stick would show up on the next read of a limit. That read would return a value written after the lock instead of the frozen one. A re-initialise that misses a field would leave a stale value in the very next read-back of that address.

Gating errors in the interrupt path show at irq_n_o, one clock after a thermal event or three clocks after a voltage-ID pin rises. Tracking the divisor selects separately from the stored nibble would make fan_div_o disagree with the 47h read-back as soon as a write lands.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;

    localparam int DW = 8;
    localparam int AW = 8;

    localparam logic [AW-1:0] A_LIM_INT = 8'h13;
    localparam logic [AW-1:0] A_LIM_EXT = 8'h14;
    localparam logic [AW-1:0] A_CHMODE  = 8'h16;
    localparam logic [AW-1:0] A_CFG1    = 8'h40;
    localparam logic [AW-1:0] A_VIDFAN  = 8'h47;
    localparam logic [AW-1:0] A_VID4    = 8'h49;
    localparam logic [AW-1:0] A_CFG2    = 8'h4A;

    typedef struct packed {
        logic [6:0]    cfg1;
        logic [DW-1:0] chmode;
        logic [DW-1:0] lim_int;
        logic [DW-1:0] lim_ext;
        logic [3:0]    fan_sel;
        logic [6:0]    vid4_spare;
        logic          irq4_en;
        logic          irq3_en;
        logic          acpi;
        logic          lock_ext;
        logic          lock_int;
        logic          therm_mask;
    } regs_t;

endpackage

// File: rtl/hwmon_regs.sv
module hwmon_regs
    import hwmon_pkg::*;
#(
    parameter logic [7:0] LIM_INT_RST = 8'h50,
    parameter logic [7:0] LIM_EXT_RST = 8'h55
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [4:0]    vid_i,
    output logic [DW-1:0] rd_data_o,
    output regs_t         regs_o
);

    localparam regs_t RST_VAL = '{
        cfg1:       7'h00,
        chmode:     8'h00,
        lim_int:    LIM_INT_RST,
        lim_ext:    LIM_EXT_RST,
        fan_sel:    4'b0101,
        vid4_spare: 7'b1000000,
        default:    1'b0
    };

    regs_t regs_d, regs_q;
    logic  reinit;
    logic  addr_hit;

    always_comb begin
        regs_d   = regs_q;
        reinit   = wr_en_i && (addr_i == A_CFG1) && wr_data_i[7];
        addr_hit = 1'b1;
        rd_data_o = '0;
        case (addr_i)
            A_CFG1:    rd_data_o = {1'b0, regs_q.cfg1};
            A_CHMODE:  rd_data_o = regs_q.chmode;
            A_LIM_INT: rd_data_o = regs_q.lim_int;
            A_LIM_EXT: rd_data_o = regs_q.lim_ext;
            A_VIDFAN:  rd_data_o = {regs_q.fan_sel, vid_i[3:0]};
            A_VID4:    rd_data_o = {regs_q.vid4_spare, vid_i[4]};
            A_CFG2:    rd_data_o = {regs_q.irq4_en, regs_q.irq3_en, 2'b00,
                                    regs_q.acpi, regs_q.lock_ext,
                                    regs_q.lock_int, regs_q.therm_mask};
            default:   addr_hit = 1'b0;
        endcase
        if (reinit) begin
            regs_d = RST_VAL;
        end else if (wr_en_i) begin
            case (addr_i)
                A_CFG1:    regs_d.cfg1 = wr_data_i[6:0];
                A_CHMODE:  regs_d.chmode = wr_data_i;
                A_LIM_INT: if (!regs_q.lock_int) regs_d.lim_int = wr_data_i;
                A_LIM_EXT: if (!regs_q.lock_ext) regs_d.lim_ext = wr_data_i;
                A_VIDFAN:  regs_d.fan_sel = wr_data_i[7:4];
                A_VID4:    regs_d.vid4_spare = wr_data_i[7:1];
                A_CFG2: begin
                    regs_d.irq4_en    = wr_data_i[7];
                    regs_d.irq3_en    = wr_data_i[6];
                    regs_d.acpi       = wr_data_i[3];
                    regs_d.lock_ext   = regs_q.lock_ext | wr_data_i[2];
                    regs_d.lock_int   = regs_q.lock_int | wr_data_i[1];
                    regs_d.therm_mask = wr_data_i[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= RST_VAL;
        else         regs_q <= regs_d;
    end

    assign regs_o = regs_q;

    AST_LOCK_INT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (regs_q.lock_int && wr_en_i && addr_i == A_LIM_INT) |=> $stable(regs_q.lim_int)); // R5
    AST_LOCK_EXT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (regs_q.lock_ext && wr_en_i && addr_i == A_LIM_EXT) |=> $stable(regs_q.lim_ext)); // R5
    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (regs_q.lock_int && !reinit) |=> regs_q.lock_int); // R5
    AST_REINIT_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reinit |=> (regs_q == RST_VAL)); // R6
    AST_UNIMPL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !addr_hit) |=> $stable(regs_q)); // R10

endmodule

// File: rtl/hwmon_irq.sv
module hwmon_irq #(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_EXT     = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               therm_evt_i,
    input  logic               therm_mask_i,
    input  logic               glb_en_i,
    input  logic [NUM_EXT-1:0] ext_en_i,
    input  logic [NUM_EXT-1:0] ext_pin_i,
    output logic               irq_n_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_EXT-1:0] sync;
        logic                                irq_n;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [NUM_EXT-1:0] ext_req;
    logic               therm_req;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = ext_pin_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        ext_req    = st_q.sync[SYNC_STAGES-1] & ext_en_i & {NUM_EXT{glb_en_i}};
        therm_req  = therm_evt_i & ~therm_mask_i;
        st_d.irq_n = ~(therm_req | (|ext_req));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sync  <= '0;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n_o = st_q.irq_n;

    AST_MASK_BLOCKS_THERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (therm_mask_i && ext_req == '0) |=> irq_n_o); // R7
    AST_THERM_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (therm_evt_i && !therm_mask_i) |=> !irq_n_o); // R7
    AST_NO_GLOBAL_NO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!glb_en_i && !therm_req) |=> irq_n_o); // R9

endmodule

// File: rtl/hwmon_regbank.sv
module hwmon_regbank
    import hwmon_pkg::*;
#(
    parameter int         NUM_FANS    = 2,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] LIM_INT_RST = 8'h50,
    parameter logic [7:0] LIM_EXT_RST = 8'h55
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [7:0]            addr_i,
    input  logic                  wr_en_i,
    input  logic [7:0]            wr_data_i,
    output logic [7:0]            rd_data_o,
    input  logic [4:0]            vid_i,
    input  logic                  therm_evt_i,
    output logic                  irq_n_o,
    output logic                  acpi_mode_o,
    output logic [NUM_FANS*4-1:0] fan_div_o
);

    localparam int SEL_W = 2;

    regs_t regs;

    hwmon_regs #(
        .LIM_INT_RST (LIM_INT_RST),
        .LIM_EXT_RST (LIM_EXT_RST)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .vid_i     (vid_i),
        .rd_data_o (rd_data_o),
        .regs_o    (regs)
    );

    hwmon_irq #(
        .SYNC_STAGES (SYNC_STAGES),
        .NUM_EXT     (2)
    ) u_irq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .therm_evt_i  (therm_evt_i),
        .therm_mask_i (regs.therm_mask),
        .glb_en_i     (regs.chmode[7]),
        .ext_en_i     ({regs.irq4_en, regs.irq3_en}),
        .ext_pin_i    (vid_i[4:3]),
        .irq_n_o      (irq_n_o)
    );

    assign acpi_mode_o = regs.acpi;

    generate
        for (genvar f = 0; f < NUM_FANS; f++) begin : g_fan
            logic [SEL_W-1:0] sel;
            assign sel = regs.fan_sel[f*SEL_W +: SEL_W];
            assign fan_div_o[f*4 +: 4] = 4'b0001 << sel;

            AST_FAN_MATCHES_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (addr_i == A_VIDFAN) |-> (fan_div_o[f*4 +: 4] ==
                    (4'b0001 << rd_data_o[4 + f*SEL_W +: SEL_W]))); // R4
        end
    endgenerate

    AST_VID_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == A_VIDFAN) |-> (rd_data_o[3:0] == vid_i[3:0])); // R2
    AST_VID4_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == A_VID4) |-> (rd_data_o[0] == vid_i[4])); // R3

endmodule

// File: tb/hwmon_regbank_test.sv
module hwmon_regbank_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [4:0] vid = 5'b00000;
    logic       therm = 1'b0;
    logic       irq_n;
    logic       acpi;
    logic [7:0] fan_div;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [6:0] m_cfg1;
    logic [7:0] m_ch, m_li, m_le, m_c2;
    logic [3:0] m_vf;
    logic [6:0] m_v4;

    always #2 clk = ~clk;

    hwmon_regbank uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .addr_i      (addr),
        .wr_en_i     (wr_en),
        .wr_data_i   (wdata),
        .rd_data_o   (rdata),
        .vid_i       (vid),
        .therm_evt_i (therm),
        .irq_n_o     (irq_n),
        .acpi_mode_o (acpi),
        .fan_div_o   (fan_div)
    );

    task automatic model_reset();
        m_cfg1 = 7'h00;
        m_ch   = 8'h00;
        m_li   = 8'h50;
        m_le   = 8'h55;
        m_c2   = 8'h00;
        m_vf   = 4'b0101;
        m_v4   = 7'b1000000;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'h40: if (d[7]) model_reset(); else m_cfg1 = d[6:0];
            8'h16: m_ch = d;
            8'h13: if (!m_c2[1]) m_li = d;
            8'h14: if (!m_c2[2]) m_le = d;
            8'h47: m_vf = d[7:4];
            8'h49: m_v4 = d[7:1];
            8'h4A: m_c2 = {d[7:6], 2'b00, d[3], d[2] | m_c2[2], d[1] | m_c2[1], d[0]};
            default: ;
        endcase
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h40: return {1'b0, m_cfg1};
            8'h16: return m_ch;
            8'h13: return m_li;
            8'h14: return m_le;
            8'h47: return {m_vf, vid[3:0]};
            8'h49: return {m_v4, vid[4]};
            8'h4A: return m_c2;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_fan();
        return {4'b0001 << m_vf[3:2], 4'b0001 << m_vf[1:0]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_check(input string req, input logic [7:0] a);
        addr = a;
        #1;
        check(req, rdata, exp_read(a));
    endtask

    task automatic check_all(input string req);
        rd_check(req, 8'h40); rd_check(req, 8'h16); rd_check(req, 8'h13);
        rd_check(req, 8'h14); rd_check(req, 8'h47); rd_check(req, 8'h49);
        rd_check(req, 8'h4A);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        vid = 5'b10110;
        #9 rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check_all("R1");
        check("R1 irq", {7'b0, irq_n}, 8'h01);
        check("R1 fan", fan_div, exp_fan());

        // R2 low nibble of 47h is live and not writable
        wr(8'h47, 8'hFF);
        rd_check("R2", 8'h47);
        vid = 5'b00101;
        rd_check("R2 live", 8'h47);
        check("R2 value", rdata, 8'hF5);

        // R3 bit 0 of 49h is live
        wr(8'h49, 8'h00);
        rd_check("R3", 8'h49);
        vid = 5'b10101;
        rd_check("R3 live", 8'h49);
        check("R3 value", rdata, 8'h01);

        // R4 fan decode of every code
        for (int c = 0; c < 4; c++) begin
            wr(8'h47, {c[1:0], 2'(3 - c), 4'h0});
            check("R4", fan_div, exp_fan());
        end

        // R5 locks
        wr(8'h13, 8'h11);
        wr(8'h4A, 8'h02);
        wr(8'h13, 8'h22);
        rd_check("R5 int locked", 8'h13);
        check("R5 int value", rdata, 8'h11);
        wr(8'h14, 8'h33);
        wr(8'h4A, 8'h04);
        wr(8'h14, 8'h44);
        rd_check("R5 ext locked", 8'h14);
        check("R5 ext value", rdata, 8'h33);
        wr(8'h4A, 8'h00);
        rd_check("R5 sticky", 8'h4A);
        check("R5 sticky value", rdata, 8'h06);

        // R6 soft re-init
        wr(8'h40, 8'h7F);
        wr(8'h40, 8'h80);
        check_all("R6");
        check("R6 cfg2", rdata, 8'h00);
        wr(8'h13, 8'h66);
        rd_check("R6 unlocked", 8'h13);

        // R8 mode output
        wr(8'h4A, 8'h08);
        check("R8 acpi", {7'b0, acpi}, 8'h01);
        wr(8'h4A, 8'h00);
        check("R8 default", {7'b0, acpi}, 8'h00);

        // R7 thermal event and mask
        @(negedge clk); therm = 1'b1;
        @(negedge clk);
        check("R7 unmasked", {7'b0, irq_n}, 8'h00);
        wr(8'h4A, 8'h01);
        @(negedge clk);
        check("R7 masked", {7'b0, irq_n}, 8'h01);
        therm = 1'b0;
        wr(8'h4A, 8'h00);

        // R9 external interrupt on vid[3]
        vid = 5'b00000;
        wr(8'h4A, 8'hC0);
        @(negedge clk); vid = 5'b01000;
        repeat (3) @(negedge clk);
        check("R9 no global", {7'b0, irq_n}, 8'h01);
        vid = 5'b00000;
        wr(8'h16, 8'h80);
        repeat (3) @(negedge clk);
        vid = 5'b01000;
        @(negedge clk); @(negedge clk);
        check("R9 two clocks", {7'b0, irq_n}, 8'h01);
        @(negedge clk);
        check("R9 three clocks", {7'b0, irq_n}, 8'h00);
        vid = 5'b00000;
        repeat (3) @(negedge clk);
        vid = 5'b10000;
        repeat (3) @(negedge clk);
        check("R9 vid4", {7'b0, irq_n}, 8'h00);
        vid = 5'b00000;
        repeat (3) @(negedge clk);
        check("R9 released", {7'b0, irq_n}, 8'h01);

        // R10 unimplemented addresses
        wr(8'h20, 8'hFF);
        rd_check("R10 read", 8'h20);
        check_all("R10 untouched");
        wr(8'h4A, 8'h30);
        rd_check("R10 reserved bits", 8'h4A);

        // random mix, R1 to R6, R8 and R10 against the model
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a, d;
            int pick;
            pick = $urandom_range(0, 7);
            case (pick)
                0: a = 8'h13; 1: a = 8'h14; 2: a = 8'h16; 3: a = 8'h40;
                4: a = 8'h47; 5: a = 8'h49; 6: a = 8'h4A;
                default: a = 8'($urandom);
            endcase
            d = 8'($urandom);
            if (a == 8'h40 && $urandom_range(0, 7) != 0) d[7] = 1'b0;
            vid = 5'($urandom);
            wr(a, d);
            rd_check("R2 R3 R5 R6 R10 random", 8'($urandom_range(0, 1) != 0 ? a : 8'h13));
            check("R4 random", fan_div, exp_fan());
            check("R8 random", {7'b0, acpi}, {7'b0, m_c2[3]});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule